// File: doc/BRIEF.md
# Streaming Block Transposer

This block turns a stream of square element blocks from row order into column order. Each accepted input word carries one full row of a block, with one element per lane. Each output word carries one full column, with one element per lane, taken from every row. Blocks follow each other with no gap. The next block loads while the current one drains, so a continuous input stream gives a continuous output stream.

The datapath has three parts. An input triangle delays lane j by j beats. A crossbar then rotates the lanes, and its rotation advances with a beat counter. An output triangle mirrors the input one and delays output lane r by LANES-1-r beats. Together they hold about one block of storage, with no parallel-load register array. Every delay line and the counter move only on beats where `valid_in` is high. A beat with `valid_in` low freezes the whole block. The output of a block's last columns therefore comes out alongside the first rows of the next block, or alongside trailing fill beats.

Top module: `xp_transposer`

## Requirements
- R1: While `rst` is high at a clock edge, the beat counter returns to zero and the valid history clears. In the cycle after reset, `valid_out` is low.
- R2: Call the first accepted beat after reset beat 0, and number a block's rows 0..LANES-1. For a block whose row 0 is accepted at beat b, the output word shown during accepted beat b+LANES-1+k is column k. Lane r of that word holds element k of row r.
- R3: After reset, `valid_out` stays low for the first LANES-1 accepted beats and first goes high on accepted beat LANES-1.
- R4: When blocks are fed back to back, `valid_out` is high on every accepted beat from beat LANES-1 onward. No idle cycle is inserted between blocks.
- R5: A cycle with `valid_in` low leaves every delay line and the beat counter unchanged. Inserting such cycles anywhere in the stream does not change the sequence of valid output words.
- R6: `valid_out` is never high in a cycle where `valid_in` is low.
- R7: Lane i of `data_in` and `data_out` occupies bits [i*ELEM_W +: ELEM_W]. Element c of an input row sits in lane c. The element from row r sits in lane r of an output word.
- R8: A reset in the middle of a block discards the partly loaded rows. The first block fed after the reset is transposed alone, with the latency of R3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| valid_in | input | 1 | Current `data_in` row is accepted this cycle |
| data_in | input | LANES*ELEM_W | One block row, element c in lane c |
| valid_out | output | 1 | `data_out` holds a transposed column |
| data_out | output | LANES*ELEM_W | One block column, row r's element in lane r |

## Verification
A block whose element values encode row and column exposes lane swaps and off-by-one rotation. Random per-block tags tell apart a word leaking from a neighbouring block. Back-to-back runs of four blocks show whether the drain and the next load overlap without gaps. Streams with a stall every third cycle separate a design that freezes on `valid_in` low from one that keeps shifting. A reset part-way through a block shows whether stale rows survive into the next block.

// File: rtl/xp_pkg.sv
package xp_pkg;

    localparam int unsigned XP_LANES  = 16;
    localparam int unsigned XP_ELEM_W = 16;

    // Input lane feeding output lane k while the beat counter reads phase:
    // input lane j lands on output lane (phase - j) mod n, so j = (phase - k) mod n.
    function automatic int unsigned xp_src_lane(input int unsigned phase,
                                                input int unsigned k,
                                                input int unsigned n);
        return (phase + n - k) % n;
    endfunction

endpackage

// File: rtl/xp_delay.sv
module xp_delay #(
    parameter int unsigned DEPTH = 1,
    parameter int unsigned W     = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         en,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);

    generate
        if (DEPTH == 0) begin : g_wire
            assign dout = din;
        end else begin : g_line
            logic [DEPTH-1:0][W-1:0] sr_d, sr_q;

            always_comb begin
                sr_d = sr_q;
                if (en) begin
                    for (int i = DEPTH - 1; i > 0; i--) begin
                        sr_d[i] = sr_q[i-1];
                    end
                    sr_d[0] = din;
                end
            end

            always_ff @(posedge clk) begin
                if (rst) sr_q <= '0;
                else     sr_q <= sr_d;
            end

            assign dout = sr_q[DEPTH-1];

            assert_delay_load_R5: assert property (@(posedge clk) disable iff (rst)
                en |=> sr_q[0] == $past(din));
            assert_delay_hold_R5: assert property (@(posedge clk) disable iff (rst)
                !en |=> $stable(sr_q));
        end
    endgenerate

endmodule

// File: rtl/xp_rotator.sv
module xp_rotator #(
    parameter int unsigned N  = 16,
    parameter int unsigned W  = 16,
    localparam int unsigned CW = $clog2(N)
) (
    input  logic [CW-1:0]  phase_i,
    input  logic [N*W-1:0] lanes_i,
    output logic [N*W-1:0] lanes_o
);

    always_comb begin
        lanes_o = '0;
        for (int unsigned k = 0; k < N; k++) begin
            lanes_o[k*W +: W] = lanes_i[xp_pkg::xp_src_lane(int'(phase_i), k, N)*W +: W];
        end
    end

endmodule

// File: rtl/xp_ctl.sv
module xp_ctl #(
    parameter int unsigned N  = 16,
    localparam int unsigned CW = $clog2(N)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          valid_in,
    output logic [CW-1:0] phase_o,
    output logic          valid_out
);

    typedef struct packed {
        logic [CW-1:0] phase;
        logic [N-2:0]  hist;
    } ctl_t;

    ctl_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (valid_in) begin
            st_d.phase = (st_q.phase == CW'(N - 1)) ? '0 : st_q.phase + 1'b1;
            st_d.hist  = {st_q.hist[N-3:0], 1'b1};
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign phase_o   = st_q.phase;
    assign valid_out = valid_in & st_q.hist[N-2];

    assert_phase_step_R5: assert property (@(posedge clk) disable iff (rst)
        valid_in |=> (int'(st_q.phase) == (int'($past(st_q.phase)) + 1) % N));
    assert_phase_hold_R5: assert property (@(posedge clk) disable iff (rst)
        !valid_in |=> $stable(st_q));
    assert_reset_clear_R1: assert property (@(posedge clk)
        $past(rst) |-> (st_q.phase == '0 && !valid_out));

endmodule

// File: rtl/xp_transposer.sv
module xp_transposer #(
    parameter int unsigned LANES  = xp_pkg::XP_LANES,
    parameter int unsigned ELEM_W = xp_pkg::XP_ELEM_W
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    valid_in,
    input  logic [LANES*ELEM_W-1:0] data_in,
    output logic                    valid_out,
    output logic [LANES*ELEM_W-1:0] data_out
);

    localparam int unsigned CW = $clog2(LANES);

    logic [CW-1:0]           phase;
    logic [LANES*ELEM_W-1:0] skew_in;
    logic [LANES*ELEM_W-1:0] rot_out;

    xp_ctl #(.N(LANES)) u_ctl (
        .clk       (clk),
        .rst       (rst),
        .valid_in  (valid_in),
        .phase_o   (phase),
        .valid_out (valid_out)
    );

    generate
        for (genvar j = 0; j < LANES; j++) begin : g_in
            xp_delay #(.DEPTH(j), .W(ELEM_W)) u_dly (
                .clk  (clk),
                .rst  (rst),
                .en   (valid_in),
                .din  (data_in[j*ELEM_W +: ELEM_W]),
                .dout (skew_in[j*ELEM_W +: ELEM_W])
            );
        end
    endgenerate

    xp_rotator #(.N(LANES), .W(ELEM_W)) u_rot (
        .phase_i (phase),
        .lanes_i (skew_in),
        .lanes_o (rot_out)
    );

    generate
        for (genvar k = 0; k < LANES; k++) begin : g_out
            xp_delay #(.DEPTH(LANES - 1 - k), .W(ELEM_W)) u_dly (
                .clk  (clk),
                .rst  (rst),
                .en   (valid_in),
                .din  (rot_out[k*ELEM_W +: ELEM_W]),
                .dout (data_out[k*ELEM_W +: ELEM_W])
            );
        end
    endgenerate

    assert_vout_needs_vin_R6: assert property (@(posedge clk) disable iff (rst)
        valid_out |-> valid_in);
    assert_rot_lane0_R2: assert property (@(posedge clk) disable iff (rst)
        rot_out[int'(phase)*ELEM_W +: ELEM_W] == data_in[ELEM_W-1:0]);
    assert_direct_lane_R7: assert property (@(posedge clk) disable iff (rst)
        data_out[(LANES-1)*ELEM_W +: ELEM_W] == skew_in[(int'(phase)+1)%LANES*ELEM_W +: ELEM_W]);

endmodule

// File: tb/sim_xp_transposer.sv
module sim_xp_transposer;

    localparam int N = 16;
    localparam int W = 16;

    logic           clk = 1'b0;
    logic           rst = 1'b1;
    logic           valid_in = 1'b0;
    logic [N*W-1:0] data_in = '0;
    logic           valid_out;
    logic [N*W-1:0] data_out;

    int n_tests = 0;
    int n_fail  = 0;

    logic [W-1:0]   mat [N][N];
    logic [N*W-1:0] expq [$];
    logic [N*W-1:0] first_word;
    int             pops;
    int             gaps;
    int             beat_no;
    string          cur_req;

    always #2 clk = ~clk;

    xp_transposer #(.LANES(N), .ELEM_W(W)) u0 (
        .clk       (clk),
        .rst       (rst),
        .valid_in  (valid_in),
        .data_in   (data_in),
        .valid_out (valid_out),
        .data_out  (data_out)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input logic [N*W-1:0] act, input logic [N*W-1:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; valid_in = 1'b0; data_in = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        expq.delete();
        pops = 0; gaps = 0; beat_no = 0;
    endtask

    task automatic make_block(input logic [7:0] tag, input bit push);
        logic [N*W-1:0] w;
        for (int r = 0; r < N; r++)
            for (int c = 0; c < N; c++)
                mat[r][c] = {tag, 4'(r), 4'(c)};
        if (push) begin
            for (int k = 0; k < N; k++) begin
                for (int r = 0; r < N; r++) w[r*W +: W] = mat[r][k];
                expq.push_back(w);
            end
        end
    endtask

    function automatic logic [N*W-1:0] row_word(input int r);
        logic [N*W-1:0] w;
        for (int c = 0; c < N; c++) w[c*W +: W] = mat[r][c];
        return w;
    endfunction

    task automatic beat(input logic v, input logic [N*W-1:0] word);
        logic [N*W-1:0] e;
        @(negedge clk);
        valid_in = v; data_in = word;
        #1;
        if (valid_out) begin
            if (expq.size() == 0) begin
                check(1'b0, cur_req, "unexpected output word", data_out, '0);
            end else begin
                e = expq.pop_front();
                if (pops == 0) first_word = data_out;
                pops++;
                check(data_out == e, cur_req, "column word", data_out, e);
            end
        end else if (v && beat_no >= N - 1) begin
            gaps++;
        end
        if (v) beat_no++;
    endtask

    task automatic feed_rows(input int count);
        for (int r = 0; r < count; r++) beat(1'b1, row_word(r));
    endtask

    task automatic flush();
        for (int i = 0; i < N - 1; i++) beat(1'b1, '0);
    endtask

    // R1 and R3: quiet after reset, first column on beat N-1
    task automatic t_reset_latency();
        cur_req = "R2";
        do_reset();
        #1;
        check(valid_out == 1'b0, "R1", "valid_out after reset", N*W'(valid_out), '0);
        make_block(8'($urandom), 1'b1);
        for (int r = 0; r < N; r++) begin
            beat(1'b1, row_word(r));
            if (r < N - 1)
                check(valid_out == 1'b0, "R3", "early valid_out", N*W'(valid_out), '0);
            else
                check(valid_out == 1'b1, "R3", "valid_out on beat N-1", N*W'(valid_out), 1);
        end
        flush();
        check(expq.size() == 0, "R2", "columns left", expq.size(), 0);
    endtask

    // R2 and R7: lane positions with a row/column coded block
    task automatic t_lane_map();
        cur_req = "R7";
        do_reset();
        make_block(8'h00, 1'b1);
        feed_rows(N);
        flush();
        check(pops == N, "R2", "column count", pops, N);
        check(first_word[3*W +: W] == 16'h0030, "R7", "lane 3 of column 0",
              first_word[3*W +: W], 16'h0030);
        check(first_word[15*W +: W] == 16'h00F0, "R7", "lane 15 of column 0",
              first_word[15*W +: W], 16'h00F0);
    endtask

    // R4: four blocks back to back, no gaps
    task automatic t_back_to_back();
        cur_req = "R4";
        do_reset();
        for (int b = 0; b < 4; b++) begin
            make_block(8'($urandom), 1'b1);
            feed_rows(N);
        end
        flush();
        check(pops == 4 * N, "R4", "column count", pops, 4 * N);
        check(gaps == 0, "R4", "idle output beats", gaps, 0);
        check(expq.size() == 0, "R4", "columns left", expq.size(), 0);
    endtask

    // R5 and R6: stall cycles freeze the pipe
    task automatic t_stalls();
        cur_req = "R5";
        do_reset();
        for (int b = 0; b < 2; b++) begin
            make_block(8'($urandom), 1'b1);
            for (int r = 0; r < N; r++) begin
                if (r % 3 == 2) begin
                    beat(1'b0, {N{16'($urandom)}});
                    check(valid_out == 1'b0, "R6", "valid_out while stalled",
                          N*W'(valid_out), '0);
                end
                beat(1'b1, row_word(r));
            end
        end
        for (int i = 0; i < N - 1; i++) begin
            if (i % 4 == 1) beat(1'b0, '1);
            beat(1'b1, '0);
        end
        check(pops == 2 * N, "R5", "column count", pops, 2 * N);
        check(expq.size() == 0, "R5", "columns left", expq.size(), 0);
    endtask

    // R8: reset part-way through a block
    task automatic t_mid_reset();
        cur_req = "R8";
        do_reset();
        make_block(8'hAA, 1'b0);
        feed_rows(7);
        do_reset();
        #1;
        check(valid_out == 1'b0, "R8", "valid_out after reset", N*W'(valid_out), '0);
        make_block(8'h55, 1'b1);
        feed_rows(N);
        flush();
        check(pops == N, "R8", "column count", pops, N);
        check(expq.size() == 0, "R8", "columns left", expq.size(), 0);
    endtask

    initial begin
        #(200000 * 4);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog expired: actual hung expected done");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        t_reset_latency();
        t_lane_map();
        t_back_to_back();
        t_stalls();
        t_mid_reset();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule